// File: doc/BRIEF.md
# Character Cell Dot Serializer

This block sits between the font fetch path and the palette lookup of a text display pipeline. Once per character time a load strobe hands it one row slice of a glyph and the cell's attribute byte in parallel. From then on it produces, on its own, one 4-bit colour index per dot: the attribute's foreground nibble where the glyph bit is set, the background nibble where it is clear. The underline/cursor flag, a line-graphics flag and a blink phase modify that choice, and an optional ninth dot widens each cell.

In graphics mode the serializer steps aside and a per-dot 4-bit pixel index from the plane logic passes straight to the output. A half-rate setting holds each dot for two clocks, which gives the wide 40-column text format. Bit 3 of the latched attribute is exported as the character-set select for the font fetch logic.

Top module: `glyph_ser`

## Requirements
- R1: A clock edge with `load_i` high latches `glyph_i` and `attr_i`; at the following edges the dots are shown one per clock, glyph bit 7 (MSB) first, starting in the cycle right after the load edge.
- R2: A dot whose glyph bit is 1 shows `attr[3:0]` (foreground); a dot whose bit is 0 shows `attr[7:4]` (background).
- R3: With `blink_en_i` high and `attr[7]` = 1 the background is `{1'b0, attr[6:4]}`, and while `blink_on_i` is low the foreground dots show that background; with `blink_en_i` low, `attr[7]` is an ordinary background bit and `blink_on_i` has no effect.
- R4: `ul_i`, latched with the load, forces every dot of the cell to the foreground colour.
- R5: With `nine_dot_i` high a ninth dot follows dot 8; it repeats glyph bit 0 when `lg_i` (latched with the load) is high, and is background otherwise.
- R6: Once the last dot of a cell has been shown and no new load arrives, the output stays at the cell's background colour.
- R7: A load during a cell restarts the dot sequence at the MSB of the new glyph in the next cycle.
- R8: With `half_rate_i` high every dot is held for two clocks.
- R9: With `gfx_mode_i` high, `color_o` equals `pix_i` in the same cycle; glyph, attribute and flags are ignored.
- R10: `char_sel_o` equals bit 3 of the latched attribute.
- R11: After reset nothing is latched: `color_o` is 0 and `char_sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Parallel load strobe, once per character |
| glyph_i | input | 8 | Glyph row slice |
| attr_i | input | 8 | Attribute byte (fg low nibble, bg high nibble) |
| ul_i | input | 1 | Underline/cursor for this cell |
| lg_i | input | 1 | Line-graphics character (extends into ninth dot) |
| nine_dot_i | input | 1 | Nine-dot cell width |
| half_rate_i | input | 1 | Hold each dot for two clocks |
| blink_en_i | input | 1 | Attribute bit 7 means blink |
| blink_on_i | input | 1 | Blink phase, high = visible |
| gfx_mode_i | input | 1 | Graphics pass-through |
| pix_i | input | 4 | Serial pixel index in graphics mode |
| color_o | output | 4 | Colour index per dot |
| char_sel_o | output | 1 | Character-set select |

## Verification
The bench builds the block with its default 8-dot glyph and 4-bit colour index, so a full nine-dot cell, the post-cell background hold and the counter's saturation point are all reached within a dozen clocks. With those values each attribute nibble maps to a single hex digit, which lets the vector table state whole dot sequences as hex words and makes blink, underline and line-graphics cases readable side by side.

// File: rtl/glyph_ser_pkg.sv
package glyph_ser_pkg;
  localparam int unsigned COLOR_W = 4;
  typedef logic [COLOR_W-1:0] color_t;
endpackage

// File: rtl/glyph_ser_shift.sv
module glyph_ser_shift #(
  parameter int unsigned GLYPH_W = 8,
  parameter int unsigned ATTR_W  = 8,
  localparam int unsigned CNT_W  = $clog2(GLYPH_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              half_rate_i,
  input  logic              nine_dot_i,
  input  logic [GLYPH_W-1:0] glyph_i,
  input  logic [ATTR_W-1:0]  attr_i,
  input  logic              ul_i,
  input  logic              lg_i,
  output logic              dot_on_o,
  output logic [ATTR_W-1:0]  attr_o
);
  localparam int unsigned EXT_N = 1 << CNT_W;

  logic [GLYPH_W-1:0] glyph_q;
  logic [ATTR_W-1:0]  attr_q;
  logic               ul_q, lg_q, phase_q;
  logic [CNT_W-1:0]   dot_q, last_dot;
  logic [EXT_N-1:0]   dot_bits;
  logic               adv, live;

  assign last_dot = nine_dot_i ? CNT_W'(GLYPH_W + 1) : CNT_W'(GLYPH_W);
  assign adv      = !half_rate_i || phase_q;
  assign live     = dot_q < last_dot;

  // dot index d maps to glyph bit GLYPH_W-1-d; slot GLYPH_W is the ninth dot
  always_comb begin
    dot_bits = '0;
    dot_bits[GLYPH_W] = lg_q & glyph_q[0];
  end
  for (genvar d = 0; d < GLYPH_W; d++) begin : g_rev
    always_comb dot_bits_rev[d] = glyph_q[GLYPH_W-1-d];
  end
  logic [GLYPH_W-1:0] dot_bits_rev;
  logic [EXT_N-1:0]   dot_map;
  assign dot_map = dot_bits | EXT_N'(dot_bits_rev);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glyph_q <= '0;
      attr_q  <= '0;
      ul_q    <= 1'b0;
      lg_q    <= 1'b0;
      phase_q <= 1'b0;
      dot_q   <= CNT_W'(GLYPH_W + 1);
    end else if (load_i) begin
      glyph_q <= glyph_i;
      attr_q  <= attr_i;
      ul_q    <= ul_i;
      lg_q    <= lg_i;
      phase_q <= 1'b0;
      dot_q   <= '0;
    end else begin
      phase_q <= half_rate_i ? ~phase_q : 1'b0;
      if (adv && live) dot_q <= dot_q + 1'b1;
    end
  end

  assign dot_on_o = live & (dot_map[dot_q] | ul_q);
  assign attr_o   = attr_q;

  // R6
  no_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_q <= CNT_W'(GLYPH_W + 1));
  // R7
  load_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> dot_q == '0);
  // R8
  dot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv) |=> $stable(dot_q));
endmodule

// File: rtl/glyph_ser_color.sv
module glyph_ser_color
  import glyph_ser_pkg::*;
#(
  parameter int unsigned ATTR_W = 2 * COLOR_W
) (
  input  logic              dot_on_i,
  input  logic [ATTR_W-1:0] attr_i,
  input  logic              blink_en_i,
  input  logic              blink_on_i,
  output color_t            color_o
);
  logic   blink_cell, show_fg;
  color_t fg, bg;

  assign blink_cell = blink_en_i & attr_i[ATTR_W-1];
  assign fg = attr_i[COLOR_W-1:0];
  assign bg = blink_cell ? {1'b0, attr_i[ATTR_W-2:COLOR_W]} : attr_i[ATTR_W-1:COLOR_W];
  assign show_fg = dot_on_i & ~(blink_cell & ~blink_on_i);
  assign color_o = show_fg ? fg : bg;
endmodule

// File: rtl/glyph_ser.sv
module glyph_ser
  import glyph_ser_pkg::*;
#(
  parameter int unsigned GLYPH_W = 8,
  localparam int unsigned ATTR_W = 2 * COLOR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [GLYPH_W-1:0] glyph_i,
  input  logic [ATTR_W-1:0]  attr_i,
  input  logic               ul_i,
  input  logic               lg_i,
  input  logic               nine_dot_i,
  input  logic               half_rate_i,
  input  logic               blink_en_i,
  input  logic               blink_on_i,
  input  logic               gfx_mode_i,
  input  logic [COLOR_W-1:0] pix_i,
  output logic [COLOR_W-1:0] color_o,
  output logic               char_sel_o
);
  logic              dot_on;
  logic [ATTR_W-1:0] attr_q;
  color_t            text_color;

  glyph_ser_shift #(.GLYPH_W(GLYPH_W), .ATTR_W(ATTR_W)) u_shift (
    .clk_i, .rst_ni, .load_i, .half_rate_i, .nine_dot_i,
    .glyph_i, .attr_i, .ul_i, .lg_i,
    .dot_on_o(dot_on), .attr_o(attr_q)
  );

  glyph_ser_color #(.ATTR_W(ATTR_W)) u_color (
    .dot_on_i(dot_on), .attr_i(attr_q), .blink_en_i, .blink_on_i,
    .color_o(text_color)
  );

  assign color_o    = gfx_mode_i ? pix_i : text_color;
  assign char_sel_o = attr_q[3];

  // R10
  char_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> char_sel_o == $past(attr_i[3]));
  // R3
  blink_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gfx_mode_i && blink_en_i && !blink_on_i && attr_q[ATTR_W-1])
      |-> color_o == {1'b0, attr_q[ATTR_W-2:COLOR_W]});
  // R9
  gfx_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gfx_mode_i && $stable(pix_i) && $past(gfx_mode_i)) |-> $stable(color_o));
endmodule

// File: tb/glyph_ser_test.sv
module glyph_ser_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic load = 0, ul = 0, lg = 0, nine = 0, half = 0, ben = 0, bon = 1, gfx = 0;
  logic [7:0] glyph = 0, attr = 0;
  logic [3:0] pix = 0, color;
  logic       csel;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  glyph_ser uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .glyph_i(glyph), .attr_i(attr),
    .ul_i(ul), .lg_i(lg), .nine_dot_i(nine), .half_rate_i(half),
    .blink_en_i(ben), .blink_on_i(bon), .gfx_mode_i(gfx), .pix_i(pix),
    .color_o(color), .char_sel_o(csel)
  );

  // {glyph, attr, ul, lg, nine, blink_en, blink_on, 9 expected dots MSB nibble first}
  localparam logic [56:0] VEC [8] = '{
    {8'hA5, 8'h1E, 5'b00000, 36'hE1E11E1E0},  // R1 R2
    {8'h81, 8'h70, 5'b01100, 36'h077777700},  // R5 lg repeats bit0
    {8'h81, 8'h70, 5'b00100, 36'h077777707},  // R5 ninth is bg
    {8'h00, 8'h4A, 5'b10000, 36'hAAAAAAAA0},  // R4
    {8'hF0, 8'hC3, 5'b00011, 36'h333344440},  // R3 blink visible
    {8'hF0, 8'hC3, 5'b00010, 36'h444444440},  // R3 blink off phase
    {8'hF0, 8'hC3, 5'b00001, 36'h3333CCCC0},  // R3 blink disabled
    {8'hF0, 8'h43, 5'b00010, 36'h333344440}   // R3 no blink bit
  };

  task automatic chk(input logic [3:0] exp, input string req);
    checks++;
    if (color !== exp) begin
      fails++;
      $display("FAIL %s: color_o=%h expected %h", req, color, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] g, input logic [7:0] a);
    @(negedge clk);
    glyph = g; attr = a; load = 1;
    @(negedge clk);
    load = 0;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: timeout expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(4'h0, "R11");
    checks++;
    if (csel !== 1'b0) begin fails++; $display("FAIL R11: char_sel_o=%b expected 0", csel); end
    rst_n = 1;
    @(negedge clk);
    chk(4'h0, "R11");

    foreach (VEC[i]) begin
      {ul, lg, nine, ben, bon} = VEC[i][40:36];
      do_load(VEC[i][56:49], VEC[i][48:41]);
      for (int d = 0; d < (nine ? 9 : 8); d++) begin
        if (d > 0) @(negedge clk);
        chk(VEC[i][35-4*d -: 4], "R1/R2/R3/R4/R5 vector");
      end
    end
    // R6: after last dot of the blink-disabled cell the background C holds
    ul = 0; lg = 0; nine = 0; ben = 0; bon = 1;
    do_load(8'hF0, 8'hC3);
    repeat (8) @(negedge clk);
    chk(4'hC, "R6");
    @(negedge clk);
    chk(4'hC, "R6");

    // R7: restart mid-cell
    do_load(8'h00, 8'h52);
    repeat (3) @(negedge clk);
    do_load(8'h80, 8'h29);
    chk(4'h9, "R7");
    @(negedge clk);
    chk(4'h2, "R7");

    // R8: half rate
    half = 1;
    do_load(8'h80, 8'h21);
    chk(4'h1, "R8");
    @(negedge clk); chk(4'h1, "R8");
    @(negedge clk); chk(4'h2, "R8");
    @(negedge clk); chk(4'h2, "R8");
    half = 0;

    // R10
    do_load(8'h00, 8'h08);
    checks++;
    if (csel !== 1'b1) begin fails++; $display("FAIL R10: char_sel_o=%b expected 1", csel); end
    do_load(8'h00, 8'hF7);
    checks++;
    if (csel !== 1'b0) begin fails++; $display("FAIL R10: char_sel_o=%b expected 0", csel); end

    // R9: graphics pass-through, text data ignored
    gfx = 1; pix = 4'h5;
    #1 chk(4'h5, "R9");
    pix = 4'hB; ul = 1;
    do_load(8'hFF, 8'h3E);
    chk(4'hB, "R9");
    @(negedge clk);
    pix = 4'h0;
    #1 chk(4'h0, "R9");
    gfx = 0; ul = 0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule